// File: doc/BRIEF.md
# Demand-Driven Clock-Gating Stall Wrapper

This block wraps a synchronous core and stalls it by gating its clock. Three input channels feed the core, and each has its own availability flag. The decision to stall depends on the state of the core. In each state the core needs only some of the channels, so a missing channel that is not needed in that state never holds the core back. Because of this, the producer of an unused channel does not have to send filler data to keep the core running.

A two-state stall machine works out from its state which channels are needed and combines that with the availability flags to form an enable. The enable is captured on the falling edge of the free-running clock. The gated core clock is the free-running clock ANDed with that captured enable, so the gated clock has no glitches. The stall machine's own state register runs on the gated clock, so it advances only when the core fires. After each firing, the wrapper sends a one-cycle consume acknowledgement to each channel that was used. The core wrapped here for test is a registered accumulator.

Top module: `stall_gate_wrapper`

## Requirements
- R1: While reset is held, and right after it is released, `phase` is 0 (the start state), `acc` is 0 and all three acknowledgements are 0.
- R2: In phase 0 the core fires exactly when channels A and C are both available when the falling edge samples them. The B flag has no effect in phase 0.
- R3: In phase 1 the core fires exactly when channels B and C are both available. The A flag has no effect in phase 1.
- R4: `phase` toggles on every firing (0 to 1, then 1 to 0) and holds its value on every stalled cycle.
- R5: The enable is captured on the falling clock edge, and each captured enable of 1 produces exactly one core clock pulse. The number of firings therefore equals the number of cycles in which the needed channels were present.
- R6: One cycle after a firing, the acknowledgements mark the channels that were used: `a_ack` and `c_ack` for a phase-0 firing, `b_ack` and `c_ack` for a phase-1 firing. On any other cycle all acknowledgements are 0.
- R7: A phase-0 firing adds `a_data + c_data` to `acc`. A phase-1 firing adds `b_data + c_data`. The sum wraps modulo 2^ACC_W.
- R8: On a stalled cycle `acc` keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| a_valid | input | 1 | Channel A availability |
| a_data | input | DATA_W | Channel A data |
| b_valid | input | 1 | Channel B availability |
| b_data | input | DATA_W | Channel B data |
| c_valid | input | 1 | Channel C availability |
| c_data | input | DATA_W | Channel C data |
| a_ack | output | 1 | Channel A consumed by the last firing |
| b_ack | output | 1 | Channel B consumed by the last firing |
| c_ack | output | 1 | Channel C consumed by the last firing |
| phase | output | 1 | Stall machine state (0 or 1) |
| acc | output | ACC_W | Accumulator value of the test core |

## Verification
The bench builds the block with DATA_W=8 and ACC_W=12. With these widths a few hundred firings carry the accumulator through several wraparounds, so the modulo behaviour is exercised without a long run. First, every one of the eight availability patterns is applied in each of the two phases, which covers each firing and stall condition, including an absent B in phase 0 and an absent A in phase 1. After that, a long pseudo-random run is compared cycle by cycle with an arithmetic model of the state, the sum and the acknowledgements, and the firing count is checked at the end.

// File: rtl/sgw_pkg.sv
package sgw_pkg;
  localparam int NCH   = 3;
  localparam int CH_A  = 0;
  localparam int CH_B  = 1;
  localparam int CH_C  = 2;

  typedef enum logic {PH_S0 = 1'b0, PH_S1 = 1'b1} phase_t;

  // Channels the core consumes in each phase (bit index = channel).
  localparam logic [NCH-1:0] NEED_S0 = 3'b101;
  localparam logic [NCH-1:0] NEED_S1 = 3'b110;

  function automatic logic [NCH-1:0] need_mask(input phase_t ph);
    return (ph == PH_S1) ? NEED_S1 : NEED_S0;
  endfunction
endpackage

// File: rtl/sgw_stall_fsm.sv
module sgw_stall_fsm
  import sgw_pkg::*;
(
  input  logic           clk,
  input  logic           gclk,
  input  logic           rst_n,
  input  logic [NCH-1:0] avail,
  input  logic           en_q,
  output phase_t         state_q,
  output logic           grant
);
  phase_t state_d;
  logic [NCH-1:0] need;

  // Next-state and enable logic.
  always_comb begin
    need  = need_mask(state_q);
    grant = ((avail & need) == need);
    // Y = ~y & a & c
    state_d = ((state_q == PH_S0) && avail[CH_A] && avail[CH_C]) ? PH_S1 : PH_S0;
  end

  // The state register runs on the gated clock, so it only advances on a firing.
  always_ff @(posedge gclk or negedge rst_n) begin
    if (!rst_n) state_q <= PH_S0;
    else        state_q <= state_d;
  end

  assert_hold_when_stalled_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> $stable(state_q));
  assert_toggle_on_fire_R4: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> (state_q != $past(state_q)));
endmodule

// File: rtl/sgw_clock_gate.sv
module sgw_clock_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic grant,
  output logic en_q,
  output logic gclk
);
  // The enable is captured while clk is low, so it never changes during the high phase.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= grant;
  end

  assign gclk = clk & en_q;

  assert_enable_capture_R5: assert property (@(negedge clk) disable iff (!rst_n)
    grant |=> en_q);
  assert_stall_capture_R5: assert property (@(negedge clk) disable iff (!rst_n)
    !grant |=> !en_q);
endmodule

// File: rtl/sgw_accum_core.sv
module sgw_accum_core
  import sgw_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ACC_W  = 12
) (
  input  logic              clk,
  input  logic              gclk,
  input  logic              rst_n,
  input  logic              en_q,
  input  phase_t            phase,
  input  logic [DATA_W-1:0] a_data,
  input  logic [DATA_W-1:0] b_data,
  input  logic [DATA_W-1:0] c_data,
  output logic [ACC_W-1:0]  acc_q
);
  localparam int SUM_W = DATA_W + 1;

  logic [DATA_W-1:0] first_op;
  logic [SUM_W-1:0]  pair_sum;
  logic [ACC_W-1:0]  acc_d;

  always_comb begin
    first_op = (phase == PH_S1) ? b_data : a_data;
    pair_sum = {1'b0, first_op} + {1'b0, c_data};
    acc_d    = acc_q + ACC_W'(pair_sum);
  end

  always_ff @(posedge gclk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assert_acc_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> $stable(acc_q));
endmodule

// File: rtl/stall_gate_wrapper.sv
module stall_gate_wrapper
  import sgw_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ACC_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_valid,
  input  logic [DATA_W-1:0] a_data,
  input  logic              b_valid,
  input  logic [DATA_W-1:0] b_data,
  input  logic              c_valid,
  input  logic [DATA_W-1:0] c_data,
  output logic              a_ack,
  output logic              b_ack,
  output logic              c_ack,
  output logic              phase,
  output logic [ACC_W-1:0]  acc
);
  logic [1:0]     rst_sync_q;
  logic           rst_s_n;
  logic [NCH-1:0] avail;
  logic [NCH-1:0] need_now;
  logic [NCH-1:0] ack_q;
  logic           grant;
  logic           en_q;
  logic           gclk;
  phase_t         state_q;

  // Reset is asserted asynchronously and released on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  assign avail = {c_valid, b_valid, a_valid};

  sgw_stall_fsm u_fsm (
    .clk     (clk),
    .gclk    (gclk),
    .rst_n   (rst_s_n),
    .avail   (avail),
    .en_q    (en_q),
    .state_q (state_q),
    .grant   (grant)
  );

  sgw_clock_gate u_gate (
    .clk   (clk),
    .rst_n (rst_s_n),
    .grant (grant),
    .en_q  (en_q),
    .gclk  (gclk)
  );

  sgw_accum_core #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_core (
    .clk    (clk),
    .gclk   (gclk),
    .rst_n  (rst_s_n),
    .en_q   (en_q),
    .phase  (state_q),
    .a_data (a_data),
    .b_data (b_data),
    .c_data (c_data),
    .acc_q  (acc)
  );

  assign need_now = need_mask(state_q);

  // Consume acknowledgements: one free-clock cycle after each firing.
  for (genvar ch = 0; ch < NCH; ch++) begin : g_ack
    always_ff @(posedge clk or negedge rst_s_n) begin
      if (!rst_s_n) ack_q[ch] <= 1'b0;
      else          ack_q[ch] <= en_q & need_now[ch];
    end
  end

  assign a_ack = ack_q[CH_A];
  assign b_ack = ack_q[CH_B];
  assign c_ack = ack_q[CH_C];
  assign phase = state_q;

  assert_ack_pairing_R6: assert property (@(posedge clk) disable iff (!rst_s_n)
    c_ack == (a_ack ^ b_ack));
  assert_ack_after_fire_R6: assert property (@(posedge clk) disable iff (!rst_s_n)
    en_q |=> c_ack);
endmodule

// File: tb/stall_gate_wrapper_test.sv
`timescale 1ns/1ps
module stall_gate_wrapper_test;
  localparam int DATA_W = 8;
  localparam int ACC_W  = 12;

  logic clk = 1'b0;
  logic rst_n;
  logic a_valid, b_valid, c_valid;
  logic [DATA_W-1:0] a_data, b_data, c_data;
  logic a_ack, b_ack, c_ack, phase;
  logic [ACC_W-1:0] acc;

  int checks = 0;
  int errors = 0;
  int ref_fires = 0;
  int seen_fires = 0;
  logic ref_y = 1'b0;
  logic [ACC_W-1:0] ref_acc = '0;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  stall_gate_wrapper #(.DATA_W(DATA_W), .ACC_W(ACC_W)) uut (
    .clk(clk), .rst_n(rst_n),
    .a_valid(a_valid), .a_data(a_data),
    .b_valid(b_valid), .b_data(b_data),
    .c_valid(c_valid), .c_data(c_data),
    .a_ack(a_ack), .b_ack(b_ack), .c_ack(c_ack),
    .phase(phase), .acc(acc)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic next_rand();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  // Entered at posedge+1; drives one cycle and checks after the following posedge.
  task automatic run_cycle(input logic [2:0] v, input logic [7:0] da,
                           input logic [7:0] db, input logic [7:0] dc);
    logic [2:0] need;
    logic fire;
    logic y_before;
    {c_valid, b_valid, a_valid} = v;
    a_data = da; b_data = db; c_data = dc;
    need = ref_y ? 3'b110 : 3'b101;
    fire = ((v & need) == need);
    y_before = ref_y;
    @(posedge clk); #1;
    if (fire) begin
      ref_acc = ref_acc + ACC_W'(int'(y_before ? db : da) + int'(dc));
      ref_y = ~ref_y;
      ref_fires++;
    end
    if (c_ack) seen_fires++;
    if (y_before) chk("R3 fire in phase 1", int'(c_ack), int'(fire));
    else          chk("R2 fire in phase 0", int'(c_ack), int'(fire));
    chk("R6 a_ack", int'(a_ack), int'(fire & ~y_before));
    chk("R6 b_ack", int'(b_ack), int'(fire & y_before));
    chk("R4 phase", int'(phase), int'(ref_y));
    if (fire) chk("R7 acc sum", int'(acc), int'(ref_acc));
    else      chk("R8 acc held", int'(acc), int'(ref_acc));
  endtask

  task automatic goto_phase(input logic target);
    if (ref_y != target) run_cycle(ref_y ? 3'b110 : 3'b101, 8'd3, 8'd5, 8'd7);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    {a_valid, b_valid, c_valid} = 3'b111;
    a_data = 8'hFF; b_data = 8'hFF; c_data = 8'hFF;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 phase in reset", int'(phase), 0);
    chk("R1 acc in reset", int'(acc), 0);
    chk("R1 acks in reset", int'({a_ack, b_ack, c_ack}), 0);
    {a_valid, b_valid, c_valid} = 3'b000;
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 phase after release", int'(phase), 0);
    chk("R1 acc after release", int'(acc), 0);
    chk("R1 acks after release", int'({a_ack, b_ack, c_ack}), 0);

    // Every availability pattern in both phases.
    for (int st = 0; st < 2; st++) begin
      for (int pat = 0; pat < 8; pat++) begin
        goto_phase(st[0]);
        run_cycle(pat[2:0], 8'(11 + pat), 8'(40 + pat), 8'(90 + st));
      end
    end

    // B withdrawn in phase 0 must not stall (R2).
    goto_phase(1'b0);
    run_cycle(3'b101, 8'd200, 8'd0, 8'd100);
    chk("R2 no stall without B", int'(phase), 1);
    // A withdrawn in phase 1 must not stall (R3).
    run_cycle(3'b110, 8'd0, 8'd250, 8'd250);
    chk("R3 no stall without A", int'(phase), 0);

    // Long pseudo-random run.
    for (int i = 0; i < 600; i++) begin
      logic [2:0] v;
      logic [7:0] da, db, dc;
      next_rand(); v = lfsr[2:0] | {lfsr[5], 2'b00};
      next_rand(); da = lfsr[7:0]; db = lfsr[15:8];
      next_rand(); dc = lfsr[7:0];
      run_cycle(v, da, db, dc);
    end

    chk("R5 firing count", seen_fires, ref_fires);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule